// File: doc/BRIEF.md
# Port Register Block with Shared-Pin Multiplexer

This block gives a processor a small set of general-purpose pins through three registers on a simple synchronous bus. An 8-bit read-only input register returns the synchronized levels of seven external pins: a power-detect line, a service-mode line, three spare inputs and two inputs that may also raise interrupts elsewhere. Interrupt generation is outside this block, and the two interrupt-capable inputs read back their levels whatever use they are put to.

An 8-bit read/write output register drives the pins. Its two top bits drive high-current outputs through inverters, so a cleared register holds those pins high. Its three low bits reach their pins through a multiplexer. A mux control register steers that multiplexer, and the alternate sources arrive as plain inputs: a processor clock, two PWM channels and a serial-interface latch strobe. None of the block's interfaces carries a data stream. Every port is a plain level, and the bus has no back-pressure: a write lands at the clock edge where the write enable is high, and a read returns data in the same cycle.

Top module: `gpio_pinmux_top`

## Requirements
- R1: After reset the output register and the mux control register both read 0. Both high-current pins (`hc_pin_n_o`) are high, `mux_pin1_o` carries port bit 1 and `mux_pin2_o` carries port bit 2.
- R2: A read at address 0 returns bit 7 = power-detect, bit 6 = service-mode, bit 5 = 0 always, bits 4:2 = the spare inputs `gp_in_i[2:0]`, bits 1:0 = `irq_in_i[1:0]`.
- R3: A change on any input pin appears in the address-0 read data after exactly two rising clock edges. After one edge the old value is still returned.
- R4: A write to address 0 has no effect on the input register read data.
- R5: A write to address 1 stores bits 7:6 and 2:0. Bits 5:3 are not stored and read back as 0.
- R6: `hc_pin_n_o[1]` is the inverse of output register bit 7 and `hc_pin_n_o[0]` is the inverse of bit 6.
- R7: `mux_pin0_o` follows `cpu_clk_i` while `clk_out_en_i` is 1. Otherwise it follows output register bit 0.
- R8: `mux_pin1_o` carries output register bit 1 when control bit 0 is 0, and `pwm1_i` when control bit 0 is 1.
- R9: Control bits 5:4 pick the source of `mux_pin2_o`: 00 gives port bit 2, 01 gives `pwm2_i`, 10 gives `latch_i`, and the invalid code 11 falls back to port bit 2.
- R10: Address 2 reads back control bits 5, 4 and 0, with all other bits 0. Address 3 reads 0.
- R11: A mux select change takes effect in the cycle after the rising edge that writes the control register, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 2 | Register address: 0 input, 1 output, 2 mux control |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register, same cycle |
| pwr_det_i | input | 1 | Power-detect pin, asynchronous |
| svc_mode_i | input | 1 | Service-mode pin, asynchronous |
| gp_in_i | input | 3 | Spare input pins, asynchronous |
| irq_in_i | input | 2 | Interrupt-capable input pins, asynchronous |
| clk_out_en_i | input | 1 | Processor clock output enable |
| cpu_clk_i | input | 1 | Processor clock to share with pin 0 |
| pwm1_i | input | 1 | PWM channel 1 level |
| pwm2_i | input | 1 | PWM channel 2 level |
| latch_i | input | 1 | Serial-interface latch strobe |
| mux_pin0_o | output | 1 | Pin shared between port bit 0 and the processor clock |
| mux_pin1_o | output | 1 | Pin shared between port bit 1 and PWM 1 |
| mux_pin2_o | output | 1 | Pin shared between port bit 2, PWM 2 and the latch strobe |
| hc_pin_n_o | output | 2 | Inverted high-current outputs for port bits 7:6 |

## Verification
The assertions assume a single bus access per cycle with the address stable across the write edge. They also assume the alternate sources and the clock enable are plain levels whose changes never coincide with the check that follows a control write. The stimulus drives every bus and pin input at the falling clock edge and holds it for a full cycle. It leaves the PWM and latch levels untouched around control writes, so each pin comparison reflects only the select that was just written. It samples results one nanosecond after the falling edge, well away from the rising edge.

// File: rtl/gpio_pinmux_pkg.sv
package gpio_pinmux_pkg;
  localparam int DW = 8;
  localparam int AW = 2;

  typedef enum logic [AW-1:0] {
    ADDR_IN   = 2'd0,
    ADDR_OUT  = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    P2_PORT  = 2'b00,
    P2_PWM   = 2'b01,
    P2_LATCH = 2'b10,
    P2_RSVD  = 2'b11
  } pin2_sel_e;

  // bits kept in the output register: 7:6 and 2:0
  localparam logic [DW-1:0] OUT_KEEP  = 8'hC7;
  // bits kept in the control register: 5:4 and 0
  localparam logic [DW-1:0] CTRL_KEEP = 8'h31;
  localparam int HC_LO = 6;
  localparam int HC_N  = 2;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= pins_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pinmux_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] port_q,
  output logic [DW-1:0] ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
      ctrl_q <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_OUT)  port_q <= wdata_i & OUT_KEEP;
      if (addr_i == ADDR_CTRL) ctrl_q <= wdata_i & CTRL_KEEP;
    end
  end

  // R5: unused bits are dropped on write
  a_r5_port_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == ADDR_OUT) |=> (port_q == ($past(wdata_i) & OUT_KEEP)));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_pinmux_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] port_q,
  input  logic [DW-1:0] ctrl_q,
  input  logic          clk_out_en_i,
  input  logic          cpu_clk_i,
  input  logic          pwm1_i,
  input  logic          pwm2_i,
  input  logic          latch_i,
  output logic          pin0_o,
  output logic          pin1_o,
  output logic          pin2_o,
  output logic [HC_N-1:0] hc_n_o
);
  pin2_sel_e sel2;
  assign sel2 = pin2_sel_e'(ctrl_q[5:4]);

  assign pin0_o = clk_out_en_i ? cpu_clk_i : port_q[0];
  assign pin1_o = ctrl_q[0] ? pwm1_i : port_q[1];

  always_comb begin
    unique case (sel2)
      P2_PWM:   pin2_o = pwm2_i;
      P2_LATCH: pin2_o = latch_i;
      default:  pin2_o = port_q[2];
    endcase
  end

  for (genvar i = 0; i < HC_N; i++) begin : g_hc
    assign hc_n_o[i] = ~port_q[HC_LO+i];
  end

  // R8: selecting PWM 1 puts it on the pin in the same cycle
  a_r8_pwm1_select: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[0]) |-> (pin1_o == pwm1_i));
endmodule

// File: rtl/gpio_pinmux_top.sv
module gpio_pinmux_top
  import gpio_pinmux_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr_i,
  input  logic          bus_we_i,
  input  logic [7:0]    bus_wdata_i,
  output logic [7:0]    bus_rdata_o,
  input  logic          pwr_det_i,
  input  logic          svc_mode_i,
  input  logic [2:0]    gp_in_i,
  input  logic [1:0]    irq_in_i,
  input  logic          clk_out_en_i,
  input  logic          cpu_clk_i,
  input  logic          pwm1_i,
  input  logic          pwm2_i,
  input  logic          latch_i,
  output logic          mux_pin0_o,
  output logic          mux_pin1_o,
  output logic          mux_pin2_o,
  output logic [1:0]    hc_pin_n_o
);
  localparam int SYNC_STAGES = 2;

  logic [DW-1:0] raw_in, sync_in, port_q, ctrl_q;

  assign raw_in = {pwr_det_i, svc_mode_i, 1'b0, gp_in_i, irq_in_i};

  gpio_in_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_i(raw_in), .sync_o(sync_in)
  );

  gpio_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr_i), .we_i(bus_we_i),
    .wdata_i(bus_wdata_i), .port_q(port_q), .ctrl_q(ctrl_q)
  );

  gpio_pin_mux u_mux (
    .clk(clk), .rst_n(rst_n), .port_q(port_q), .ctrl_q(ctrl_q),
    .clk_out_en_i(clk_out_en_i), .cpu_clk_i(cpu_clk_i),
    .pwm1_i(pwm1_i), .pwm2_i(pwm2_i), .latch_i(latch_i),
    .pin0_o(mux_pin0_o), .pin1_o(mux_pin1_o), .pin2_o(mux_pin2_o),
    .hc_n_o(hc_pin_n_o)
  );

  always_comb begin
    unique case (reg_addr_e'(bus_addr_i))
      ADDR_IN:   bus_rdata_o = sync_in;
      ADDR_OUT:  bus_rdata_o = port_q;
      ADDR_CTRL: bus_rdata_o = ctrl_q;
      default:   bus_rdata_o = '0;
    endcase
  end

  // R2: reserved input bit never reads as 1
  a_r2_rsvd_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == ADDR_IN) |-> (bus_rdata_o[5] == 1'b0));

  // R6: writing 1 to bit 7 pulls its pin low next cycle
  a_r6_hc_low: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we_i && bus_addr_i == ADDR_OUT && bus_wdata_i[7]) |=> !hc_pin_n_o[1]);

  // R9: invalid select code falls back to the port bit
  a_r9_rsvd_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we_i && bus_addr_i == ADDR_CTRL && bus_wdata_i[5:4] == 2'b11)
      |=> (mux_pin2_o == port_q[2]));
endmodule

// File: tb/sim_gpio_pinmux_top.sv
module sim_gpio_pinmux_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr_i = '0;
  logic bus_we_i = 1'b0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic pwr_det_i = 0, svc_mode_i = 0;
  logic [2:0] gp_in_i = '0;
  logic [1:0] irq_in_i = '0;
  logic clk_out_en_i = 0, cpu_clk_i = 0, pwm1_i = 0, pwm2_i = 0, latch_i = 0;
  logic mux_pin0_o, mux_pin1_o, mux_pin2_o;
  logic [1:0] hc_pin_n_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] exp;
    string      req;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #2 clk = ~clk;

  gpio_pinmux_top u0 (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // driver: present an address, queue the expected read data
  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    rd_item_t it;
    @(negedge clk);
    bus_addr_i = a;
    it.exp = exp;
    it.req = req;
    sb_q.push_back(it);
    #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr_i = a;
    bus_wdata_i = d;
    bus_we_i = 1'b1;
    @(negedge clk);
    bus_we_i = 1'b0;
  endtask

  // monitor: compare the read data against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        rd_item_t it;
        it = sb_q.pop_front();
        chk(bus_rdata_o, it.exp, it.req);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    pwm1_i = 1; pwm2_i = 1; latch_i = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(2'd1, 8'h00, "R1 out reg");
    rd(2'd2, 8'h00, "R1 ctrl reg");
    #1;
    chk({6'd0, hc_pin_n_o}, 8'h03, "R1 hc pins high");
    chk({7'd0, mux_pin1_o}, 8'h00, "R1 pin1 port");
    chk({7'd0, mux_pin2_o}, 8'h00, "R1 pin2 port");

    // R5/R6 output register
    wr(2'd1, 8'hFF);
    rd(2'd1, 8'hC7, "R5 unused bits dropped");
    #1;
    chk({6'd0, hc_pin_n_o}, 8'h00, "R6 hc pins low");
    wr(2'd1, 8'h41);
    rd(2'd1, 8'h41, "R5 readback");
    #1;
    chk({6'd0, hc_pin_n_o}, 8'h02, "R6 mixed");

    // R7 clock pin
    chk({7'd0, mux_pin0_o}, 8'h01, "R7 port bit0");
    @(negedge clk); clk_out_en_i = 1; cpu_clk_i = 0; #1;
    chk({7'd0, mux_pin0_o}, 8'h00, "R7 clock low");
    cpu_clk_i = 1; #1;
    chk({7'd0, mux_pin0_o}, 8'h01, "R7 clock high");
    wr(2'd1, 8'h06);
    clk_out_en_i = 0; #1;
    chk({7'd0, mux_pin0_o}, 8'h00, "R7 fallback");

    // R8 pin1, port bit1 = 1, pwm1 = 0
    pwm1_i = 0; pwm2_i = 0; latch_i = 1; #1;
    chk({7'd0, mux_pin1_o}, 8'h01, "R8 port");
    // R11: no change before the write edge, change right after
    @(negedge clk);
    bus_addr_i = 2'd2; bus_wdata_i = 8'h01; bus_we_i = 1;
    #1 chk({7'd0, mux_pin1_o}, 8'h01, "R11 before edge");
    @(posedge clk); #1;
    chk({7'd0, mux_pin1_o}, 8'h00, "R11 after edge");
    @(negedge clk); bus_we_i = 0; #1;
    chk({7'd0, mux_pin1_o}, 8'h00, "R8 pwm1");

    // R9 pin2 codes, port bit2 = 1, pwm2 = 0, latch = 1
    wr(2'd2, 8'h10); #1;
    chk({7'd0, mux_pin2_o}, 8'h00, "R9 pwm2");
    wr(2'd2, 8'h20); #1;
    chk({7'd0, mux_pin2_o}, 8'h01, "R9 latch");
    latch_i = 0; #1;
    chk({7'd0, mux_pin2_o}, 8'h00, "R9 latch follows");
    wr(2'd2, 8'h30); #1;
    chk({7'd0, mux_pin2_o}, 8'h01, "R9 rsvd to port");
    pwm2_i = 1; latch_i = 1;
    wr(2'd1, 8'h00); #1;
    chk({7'd0, mux_pin2_o}, 8'h00, "R9 rsvd tracks port");
    wr(2'd2, 8'h00); #1;
    chk({7'd0, mux_pin2_o}, 8'h00, "R9 code 00 port");

    // R10 ctrl readback and unmapped address
    wr(2'd2, 8'hFF);
    rd(2'd2, 8'h31, "R10 ctrl readback");
    rd(2'd3, 8'h00, "R10 unmapped");

    // R2/R3 input register
    @(negedge clk);
    pwr_det_i = 1; svc_mode_i = 0; gp_in_i = 3'b101; irq_in_i = 2'b10;
    @(posedge clk);
    rd(2'd0, 8'h00, "R3 one edge old");
    rd(2'd0, 8'h96, "R2 pattern a");
    @(negedge clk);
    pwr_det_i = 0; svc_mode_i = 1; gp_in_i = 3'b010; irq_in_i = 2'b01;
    repeat (3) @(posedge clk);
    rd(2'd0, 8'h49, "R2 pattern b");

    // R4 write to input address ignored
    wr(2'd0, 8'hFF);
    rd(2'd0, 8'h49, "R4 write ignored");

    repeat (2) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule